// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block connects a simple single-beat host request port to one x4 SDRAM device with four internal banks. After reset it holds the clock enable low, then raises it and waits a programmable stable period. It then runs the start-up sequence: precharge every bank, issue two auto-refresh commands, and load the mode register. Only after that does it accept host requests.

Each accepted request becomes a closed-page access: an activate that opens the row, one read or write, and an explicit precharge of that bank. Only one bank is open at any time. The row and column addresses share the address bus. A free-running timer raises a refresh request at a fixed interval. That request is served as soon as the current access has finished and its bank is closed. All device timing limits are parameters counted in clock cycles. Each of them must be at least 2.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While `rst` is high, `sd_cke` is 0, the command is NOP, `sd_dq_oe` is 0 and `host_ready` is 0. No command other than NOP is issued unless `sd_cke` was already high in the previous cycle.
- R2: The first command comes no earlier than `T_INIT` cycles after reset release. It is a precharge with A10=1, followed by two auto-refreshes and then a mode-register load. The mode word has A[2:0]=000 (burst of one), A3=`BURST_TYPE`, A[6:4]=`CAS_LAT` and all other bits 0. `host_ready` stays 0 until this sequence is done.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: mode load 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. A host request with `host_we`=1 issues a write, and one with `host_we`=0 issues a read.
- R4: The host address is {bank[24:23], row[22:11], column[10:0]}. Activate drives the bank on `sd_ba` and the row on A11..A0. Read and write drive the same bank, column bits 9..0 on A9..A0, column bit 10 on A11, and A10=0.
- R5: A read or write follows its activate by at least `T_RCD` cycles.
- R6: A write drives the data on `sd_dq_o` with `sd_dq_oe`=1 and `sd_dqm`=`host_wmask`, all in the write command's cycle. `sd_dq_oe` is 1 in no other cycle. A masked write leaves the stored word unchanged.
- R7: A precharge follows a write by at least `T_WR` cycles. The next activate follows that write by at least `T_WR`+`T_RP` cycles.
- R8: Activate and refresh follow a precharge by at least `T_RP` cycles. Any command follows a refresh by at least `T_RFC` cycles.
- R9: Read data is sampled from `sd_dq_i` in the cycle `CAS_LAT` cycles after the read command. It is presented on `rd_data` with a one-cycle `rd_valid` pulse in the next cycle, in request order.
- R10: A refresh is requested every `T_REFI` cycles. A refresh is issued only when no bank is open. While a refresh is pending, `host_ready` is 0, so the refresh wins over a waiting request.
- R11: Each access is one activate, one read or write to the same bank, and one precharge of that bank. A second activate is never issued while a row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Request accepted when high together with host_valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 25 | {bank, row, column} |
| host_wdata | input | 4 | Write data |
| host_wmask | input | 1 | 1 blocks storing the write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 4 | Read data |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_o | output | 4 | Data toward the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_i | input | 4 | Data from the device |

## Verification
The refresh timer can expire in the same cycle that a host request is waiting or in flight. The bench provokes this by issuing a long run of back-to-back requests with a short refresh interval, so expiries land at every point of an access. It judges the outcome in three ways: every refresh must appear only when no row is open and after the precharge gap; the gap between refreshes must stay within the interval plus one access; and every request around a collision must still return its data intact and on its latency cycle.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PREA, ST_REF1, ST_REF2, ST_MRS, ST_IDLE, ST_RW, ST_PRE
  } seq_st_e;
endpackage

// File: rtl/sdram_gap_timer.sv
// Spacing counter: loaded with N-1 when a command issues, reports
// expiry so the following command lands exactly N cycles later (N >= 2).
module sdram_gap_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= CNT_W'(RST_VAL);
    else if (load)      cnt <= load_val;
    else if (cnt > 1)   cnt <= cnt - 1'b1;
  end

  assign expire = (cnt <= 1);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int T_REFI = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(T_REFI + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (ack) pend <= 1'b0;
      if (cnt == CW'(T_REFI - 1)) begin
        cnt  <= '0;
        pend <= 1'b1;   // an expiry in the ack cycle still wins
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int CAS_LAT = 3,
  parameter int DQ_W    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic [DQ_W-1:0] dq_i,
  output logic            valid,
  output logic [DQ_W-1:0] data
);
  logic [CAS_LAT-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe  <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      pipe  <= {pipe[CAS_LAT-2:0], issue};
      valid <= pipe[CAS_LAT-1];
      if (pipe[CAS_LAT-1]) data <= dq_i;
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl import sdram_seq_pkg::*; #(
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 12,
  parameter int DQ_W       = 4,
  parameter int CAS_LAT    = 3,
  parameter bit BURST_TYPE = 1'b0,
  parameter int T_INIT     = 20000,
  parameter int T_REFI     = 1560,
  parameter int T_RCD      = 2,
  parameter int T_RP       = 2,
  parameter int T_RFC      = 7,
  parameter int T_WR       = 2,
  parameter int T_MRD      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          host_valid,
  output logic                          host_ready,
  input  logic                          host_we,
  input  logic [BANK_W+2*ROW_W-2:0]     host_addr,
  input  logic [DQ_W-1:0]               host_wdata,
  input  logic                          host_wmask,
  output logic                          rd_valid,
  output logic [DQ_W-1:0]               rd_data,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic                          sd_dqm,
  output logic [DQ_W-1:0]               sd_dq_o,
  output logic                          sd_dq_oe,
  input  logic [DQ_W-1:0]               sd_dq_i
);
  localparam int COL_W  = ROW_W - 1;             // A10 skipped
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int GAP_W  = $clog2(T_INIT + T_RFC + T_RP + T_RCD + T_WR + CAS_LAT + T_MRD + 1);
  localparam logic [ROW_W-1:0] MODE_WORD =
    {{(ROW_W-7){1'b0}}, 3'(CAS_LAT), BURST_TYPE, 3'b000};

  seq_st_e             state, ret;
  sd_cmd_e             cmd_q;
  logic                cke_q, dqm_q, oe_q, run_q;
  logic [BANK_W-1:0]   ba_q, req_bank;
  logic [ROW_W-1:0]    a_q;
  logic [DQ_W-1:0]     dq_o_q, req_data;
  logic [COL_W-1:0]    req_col;
  logic                req_we, req_mask;
  logic                gap_load, gap_exp, ref_pend, ref_ack;
  logic [GAP_W-1:0]    gap_val;

  sdram_gap_timer #(.CNT_W(GAP_W), .RST_VAL(T_INIT - 1)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .expire(gap_exp));

  sdram_refresh_timer #(.T_REFI(T_REFI)) u_refi (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend));

  sdram_rd_capture #(.CAS_LAT(CAS_LAT), .DQ_W(DQ_W)) u_rdcap (
    .clk(clk), .rst(rst), .issue(cmd_q == CMD_RD), .dq_i(sd_dq_i),
    .valid(rd_valid), .data(rd_data));

  assign host_ready = (state == ST_IDLE) && !ref_pend;

  always_comb begin
    gap_load = 1'b0;
    gap_val  = '0;
    ref_ack  = 1'b0;
    case (state)
      ST_PREA, ST_PRE:  begin gap_load = 1'b1; gap_val = GAP_W'(T_RP - 1);  end
      ST_REF1, ST_REF2: begin gap_load = 1'b1; gap_val = GAP_W'(T_RFC - 1); end
      ST_MRS:           begin gap_load = 1'b1; gap_val = GAP_W'(T_MRD - 1); end
      ST_IDLE: begin
        if (ref_pend) begin
          gap_load = 1'b1; gap_val = GAP_W'(T_RFC - 1); ref_ack = 1'b1;
        end else if (host_valid) begin
          gap_load = 1'b1; gap_val = GAP_W'(T_RCD - 1);
        end
      end
      ST_RW: begin
        gap_load = 1'b1;
        gap_val  = req_we ? GAP_W'(T_WR - 1) : GAP_W'(CAS_LAT - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_WAIT;  ret <= ST_PREA;  cmd_q <= CMD_NOP;
      cke_q <= 1'b0;     dqm_q <= 1'b1;   oe_q <= 1'b0;  run_q <= 1'b0;
      ba_q <= '0;  a_q <= '0;  dq_o_q <= '0;
      req_bank <= '0;  req_col <= '0;  req_data <= '0;
      req_we <= 1'b0;  req_mask <= 1'b0;
    end else begin
      cke_q <= 1'b1;
      cmd_q <= CMD_NOP;
      oe_q  <= 1'b0;
      dqm_q <= !run_q;
      case (state)
        ST_WAIT: if (gap_exp) state <= ret;
        ST_PREA: begin
          cmd_q <= CMD_PRE; a_q <= '0; a_q[10] <= 1'b1;
          state <= ST_WAIT; ret <= ST_REF1;
        end
        ST_REF1: begin cmd_q <= CMD_REF; state <= ST_WAIT; ret <= ST_REF2; end
        ST_REF2: begin cmd_q <= CMD_REF; state <= ST_WAIT; ret <= ST_MRS;  end
        ST_MRS: begin
          cmd_q <= CMD_MRS; a_q <= MODE_WORD; ba_q <= '0; run_q <= 1'b1;
          dqm_q <= 1'b0; state <= ST_WAIT; ret <= ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_q <= CMD_REF; state <= ST_WAIT; ret <= ST_IDLE;
          end else if (host_valid) begin
            cmd_q    <= CMD_ACT;
            ba_q     <= host_addr[ADDR_W-1 -: BANK_W];
            a_q      <= host_addr[COL_W +: ROW_W];
            req_bank <= host_addr[ADDR_W-1 -: BANK_W];
            req_col  <= host_addr[COL_W-1:0];
            req_we   <= host_we;
            req_data <= host_wdata;
            req_mask <= host_wmask;
            state    <= ST_WAIT; ret <= ST_RW;
          end
        end
        ST_RW: begin
          ba_q <= req_bank;
          a_q  <= {req_col[COL_W-1:10], 1'b0, req_col[9:0]};
          if (req_we) begin
            cmd_q <= CMD_WR; oe_q <= 1'b1; dq_o_q <= req_data; dqm_q <= req_mask;
          end else begin
            cmd_q <= CMD_RD;
          end
          state <= ST_WAIT; ret <= ST_PRE;
        end
        ST_PRE: begin
          cmd_q <= CMD_PRE; ba_q <= req_bank; a_q[10] <= 1'b0;
          state <= ST_WAIT; ret <= ST_IDLE;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  assign sd_cke   = cke_q;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba    = ba_q;
  assign sd_addr  = a_q;
  assign sd_dqm   = dqm_q;
  assign sd_dq_o  = dq_o_q;
  assign sd_dq_oe = oe_q;
endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
module sdram_seq_ctrl_chk #(
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RFC = 7,
  parameter int T_WR  = 2
) (
  input logic clk,
  input logic rst,
  input logic sd_cke,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic a10,
  input logic sd_dq_oe,
  input logic rd_valid,
  input logic host_ready
);
  localparam logic [15:0] SAT = '1;
  logic [3:0] cmd;
  logic is_act, is_pre, is_ref, is_wr, is_rw, is_nop;
  logic [15:0] since_act, since_pre, since_ref, since_wr;

  assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act = (cmd == 4'b0011);
  assign is_pre = (cmd == 4'b0010);
  assign is_ref = (cmd == 4'b0001);
  assign is_wr  = (cmd == 4'b0100);
  assign is_rw  = is_wr || (cmd == 4'b0101);
  assign is_nop = (cmd == 4'b0111);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= SAT; since_pre <= SAT; since_ref <= SAT; since_wr <= SAT;
    end else begin
      since_act <= is_act ? 16'd1 : (since_act == SAT ? SAT : since_act + 1'b1);
      since_pre <= is_pre ? 16'd1 : (since_pre == SAT ? SAT : since_pre + 1'b1);
      since_ref <= is_ref ? 16'd1 : (since_ref == SAT ? SAT : since_ref + 1'b1);
      since_wr  <= is_wr  ? 16'd1 : (since_wr  == SAT ? SAT : since_wr  + 1'b1);
    end
  end

  p_cke_lead_r1: assert property (@(posedge clk) disable iff (rst)
    !is_nop |-> $past(sd_cke));
  p_no_autopre_r4: assert property (@(posedge clk) disable iff (rst)
    is_rw |-> !a10);
  p_rcd_r5: assert property (@(posedge clk) disable iff (rst)
    is_rw |-> since_act >= 16'(T_RCD));
  p_oe_only_write_r6: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |-> is_wr);
  p_wr_to_pre_r7: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> since_wr >= 16'(T_WR));
  p_wr_to_act_r7: assert property (@(posedge clk) disable iff (rst)
    is_act |-> since_wr >= 16'(T_WR + T_RP));
  p_rp_r8: assert property (@(posedge clk) disable iff (rst)
    (is_act || is_ref) |-> since_pre >= 16'(T_RP));
  p_rfc_r8: assert property (@(posedge clk) disable iff (rst)
    !is_nop |-> since_ref >= 16'(T_RFC));
  p_rdv_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> is_nop);
endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_WR(T_WR)
) u_chk (
  .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .a10(sd_addr[10]), .sd_dq_oe(sd_dq_oe),
  .rd_valid(rd_valid), .host_ready(host_ready)
);

// File: tb/sdram_seq_ctrl_tb.sv
module sdram_seq_ctrl_tb;
  localparam int CL = 3, TINIT = 40, TREFI = 150, TRCD = 2, TRP = 2;
  localparam int TRFC = 6, TWR = 2, TMRD = 2, SLACK = 16;
  localparam logic [11:0] MODE = {5'd0, 3'(CL), 1'b0, 3'b000};
  // R3 encodings {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 0, rst = 1;
  logic host_valid = 0, host_we = 0, host_wmask = 0;
  logic [24:0] host_addr = '0;
  logic [3:0] host_wdata = '0, sd_dq_i = '0;
  logic host_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
  logic [3:0] rd_data, sd_dq_o;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;

  always #5 clk = ~clk;

  sdram_seq_ctrl #(.CAS_LAT(CL), .T_INIT(TINIT), .T_REFI(TREFI), .T_RCD(TRCD),
    .T_RP(TRP), .T_RFC(TRFC), .T_WR(TWR), .T_MRD(TMRD)) u_dut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wmask(host_wmask), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i));

  typedef struct { bit we; logic [1:0] bank; logic [11:0] row; logic [10:0] col;
                   logic [3:0] data; bit mask; } req_t;
  req_t expq[$];
  logic [3:0] rexp[$];
  int vexp[$];
  logic [3:0] refm[int];
  logic [3:0] mem[int];
  logic [3:0] due[int];

  int nchk = 0, nfail = 0, cyc = 0, rel_cyc = 0, init_idx = 0, nref = 0;
  int last_act = -1000, last_pre = -1000, last_ref = -1000, last_wr = -1000;
  bit open = 0, cke_prev = 0, seen_ready = 0, done = 0;
  logic [1:0] obank; logic [11:0] orow;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) cyc++;

  // device model and protocol monitor, sampled mid-cycle
  always @(negedge clk) if (!rst) begin
    logic [3:0] cmd; req_t e;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (due.exists(cyc)) begin sd_dq_i = due[cyc]; due.delete(cyc); end
    else sd_dq_i = 4'h0;
    if (host_ready && !seen_ready) begin
      seen_ready = 1; chk(init_idx == 4, "R2", "ready before init done", init_idx, 4);
    end
    if (cmd != C_NOP) chk(cke_prev, "R1", "command without prior cke", cke_prev, 1);
    if (sd_dq_oe && cmd != C_WR) chk(0, "R6", "dq_oe outside write", cmd, C_WR);
    if (cmd != C_NOP && init_idx < 4) begin
      case (init_idx)
        0: begin chk(cmd == C_PRE && sd_addr[10], "R2", "first cmd precharge-all", cmd, C_PRE);
                 chk(cyc - rel_cyc >= TINIT, "R2", "stable wait", cyc - rel_cyc, TINIT); end
        1, 2: chk(cmd == C_REF, "R2", "init refresh", cmd, C_REF);
        default: begin chk(cmd == C_MRS, "R2", "mode load", cmd, C_MRS);
                       chk(sd_addr == MODE, "R2", "mode word", sd_addr, MODE); end
      endcase
      init_idx++;
    end
    case (cmd)
      C_REF: begin
        chk(!open, "R10", "refresh with open row", open, 0);
        chk(cyc - last_pre >= TRP, "R8", "pre->ref", cyc - last_pre, TRP);
        chk(cyc - last_ref >= TRFC, "R8", "ref->ref", cyc - last_ref, TRFC);
        if (nref > 0) chk(cyc - last_ref <= TREFI + SLACK, "R10", "refresh gap", cyc - last_ref, TREFI + SLACK);
        nref++; last_ref = cyc;
      end
      C_ACT: begin
        chk(!open, "R11", "activate with row open", open, 0);
        chk(cyc - last_pre >= TRP, "R8", "pre->act", cyc - last_pre, TRP);
        chk(cyc - last_ref >= TRFC, "R8", "ref->act", cyc - last_ref, TRFC);
        chk(cyc - last_wr >= TWR + TRP, "R7", "write->act", cyc - last_wr, TWR + TRP);
        if (expq.size() == 0) chk(0, "R11", "unexpected activate", 1, 0);
        else begin
          e = expq[0];
          chk(sd_ba == e.bank, "R4", "act bank", sd_ba, e.bank);
          chk(sd_addr == e.row, "R4", "act row", sd_addr, e.row);
        end
        open = 1; obank = sd_ba; orow = sd_addr; last_act = cyc;
      end
      C_RD, C_WR: begin
        chk(open && sd_ba == obank, "R11", "column cmd bank", sd_ba, obank);
        chk(cyc - last_act >= TRCD, "R5", "act->rw", cyc - last_act, TRCD);
        if (expq.size() > 0) begin
          e = expq.pop_front();
          chk(sd_addr == {e.col[10], 1'b0, e.col[9:0]}, "R4", "column map", sd_addr,
              {e.col[10], 1'b0, e.col[9:0]});
          chk(e.we == (cmd == C_WR), "R3", "command kind", cmd, e.we ? C_WR : C_RD);
        end
        if (cmd == C_WR) begin
          chk(sd_dq_oe && sd_dq_o == e.data, "R6", "write data", sd_dq_o, e.data);
          chk(sd_dqm == e.mask, "R6", "write mask", sd_dqm, e.mask);
          if (!sd_dqm) mem[int'({sd_ba, orow, sd_addr[11], sd_addr[9:0]})] = sd_dq_o;
          last_wr = cyc;
        end else begin
          int k; k = int'({sd_ba, orow, sd_addr[11], sd_addr[9:0]});
          due[cyc + CL] = mem.exists(k) ? mem[k] : 4'h0;
          vexp.push_back(cyc + CL + 1);
        end
      end
      C_PRE: begin
        if (!sd_addr[10]) begin
          chk(open && sd_ba == obank, "R11", "precharge bank", sd_ba, obank);
          chk(cyc - last_wr >= TWR, "R7", "write->pre", cyc - last_wr, TWR);
        end
        open = 0; last_pre = cyc;
      end
      C_MRS: if (init_idx > 4) chk(0, "R2", "mode load after init", 1, 0);
      default: ;
    endcase
    if (rd_valid) begin   // scoreboard monitor
      chk(vexp.size() > 0 && vexp[0] == cyc, "R9", "read valid cycle", cyc,
          vexp.size() > 0 ? vexp[0] : -1);
      if (vexp.size() > 0) void'(vexp.pop_front());
      if (rexp.size() > 0) chk(rd_data == rexp[0], "R9", "read data", rd_data, rexp[0]);
      else chk(0, "R9", "unexpected read data", rd_data, 0);
      if (rexp.size() > 0) void'(rexp.pop_front());
    end
    cke_prev = sd_cke;
  end

  task automatic do_req(bit we, logic [1:0] b, logic [11:0] r, logic [10:0] c,
                        logic [3:0] d, bit m);
    req_t e; int k;
    host_we = we; host_addr = {b, r, c}; host_wdata = d; host_wmask = m; host_valid = 1;
    while (!host_ready) @(negedge clk);
    e.we = we; e.bank = b; e.row = r; e.col = c; e.data = d; e.mask = m;
    expq.push_back(e);
    k = int'({b, r, c});
    if (we) begin if (!m) refm[k] = d; end
    else rexp.push_back(refm.exists(k) ? refm[k] : 4'h0);
    @(negedge clk);
    host_valid = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    chk(0, "all", "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!sd_cke, "R1", "cke in reset", sd_cke, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "nop in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(!sd_dq_oe && !host_ready, "R1", "oe/ready in reset", sd_dq_oe | host_ready, 0);
    rst = 0; rel_cyc = cyc;
    do_req(1, 2'd0, 12'd5,    11'd3,     4'h5, 0);
    do_req(1, 2'd3, 12'hFFF,  11'h7FF,   4'hA, 0);
    do_req(1, 2'd1, 12'h123,  11'h400,   4'h9, 0);   // column bit 10 -> A11 (R4)
    do_req(1, 2'd2, 12'd1,    11'h3FF,   4'hC, 0);
    do_req(0, 2'd0, 12'd5,    11'd3,     4'h0, 0);
    do_req(0, 2'd3, 12'hFFF,  11'h7FF,   4'h0, 0);
    do_req(0, 2'd1, 12'h123,  11'h400,   4'h0, 0);
    do_req(0, 2'd2, 12'd1,    11'h3FF,   4'h0, 0);
    do_req(1, 2'd0, 12'd5,    11'd3,     4'h3, 1);   // masked write (R6)
    do_req(0, 2'd0, 12'd5,    11'd3,     4'h0, 0);
    do_req(1, 2'd3, 12'hFFF,  11'h7FF,   4'h6, 0);
    do_req(0, 2'd3, 12'hFFF,  11'h7FF,   4'h0, 0);
    // back-to-back stream to collide with refresh expiries (R10)
    for (int i = 0; i < 80; i++) begin
      do_req(1, 2'(i), 12'(i * 37), 11'(i * 91), 4'(i % 15 + 1), 0);
      do_req(0, 2'(i), 12'(i * 37), 11'(i * 91), 4'h0, 0);
    end
    while (rexp.size() > 0 || expq.size() > 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(nref >= 2 + (cyc - rel_cyc - TINIT) / (TREFI + SLACK), "R10", "refresh count",
        nref, 2 + (cyc - rel_cyc - TINIT) / (TREFI + SLACK));
    finish_up();
  end
endmodule